// File: doc/BRIEF.md
# Toggle-Requested Single-Port RAM Port

This block wraps a word-addressed, single-port memory array. A datapath state machine drives the block from the rising clock edge. The datapath never reaches the array itself. To ask for an access it sets an address, a write flag and, for a store, the write data. It then inverts a one-bit request line. The block keeps its own copy of that line. On each falling clock edge it compares its copy with the live request, and a mismatch means one access is pending. It carries out that single load or store on the same falling edge and copies the request bit. After that the port is idle until the datapath inverts the line again.

All array traffic goes through this one port, so synthesis can map the array onto a block RAM rather than a bank of flip-flops. Because loads finish on the falling edge, a load requested at a rising edge has its data ready for the datapath to capture at the very next rising edge. The external reset is asynchronous and active low. Inside the block it is released in step with the falling edge that clocks the port logic.

Top module: `toggle_ram_port`

## Requirements
- R1: While reset is applied and after it is released, the tracked request copy is 0 and `rdata` is 0. With `req_tgl` held at 0 after reset, no access takes place.
- R2: A load is requested by inverting `req_tgl` with `wr_en` = 0 after rising edge N. `rdata` then shows the word at `addr` from the falling edge of cycle N, so it can be captured at rising edge N+1.
- R3: A store is requested by inverting `req_tgl` with `wr_en` = 1. It writes `wdata` to `addr` on the next falling edge, and a later load of that address returns the stored word.
- R4: If `req_tgl` equals the tracked copy, there is no access at all. This holds even while `wr_en`, `addr` and `wdata` change: the array and `rdata` stay unchanged.
- R5: A load leaves the array contents unchanged.
- R6: Inverting `req_tgl` on consecutive cycles gives one access per cycle, and no request is lost.
- R7: `rdata` keeps its last loaded value through idle cycles and through stores.
- R8: Both a 0-to-1 and a 1-to-0 change of `req_tgl` request an access, and one access clears the pending condition.
- R9: Every address from 0 up to the highest, 2^AW-1, can be stored and loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the datapath drives on the rising edge, the array works on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_tgl | input | 1 | Request line; inverting it asks for one access |
| wr_en | input | 1 | 1 = store, 0 = load; sampled together with the request |
| addr | input | AW | Word address |
| wdata | input | DW | Store data |
| rdata | output | DW | Load data; held between loads |

## Verification
The hardest case to reach from the ports is a request level left untouched while the other inputs keep moving. The write flag sits high and the address and data change every cycle. Nothing may reach the array, and only a later load can show that. The stimulus therefore holds `req_tgl` still for several cycles with a store-like pattern on the other inputs, then reads the targeted addresses back. It also inverts the request on every cycle of long runs, so accesses in both toggle directions land back to back.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int unsigned TRP_DW = 32;
  localparam int unsigned TRP_AW = 6;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/trp_rst_sync.sv
module trp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/trp_req_track.sv
module trp_req_track
  import trp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_q,
  input  logic      req_tgl,
  input  logic      wr_en,
  output logic      fire,
  output logic      seen_q,
  output acc_kind_e kind
);
  logic seen_d;

  always_comb begin
    fire   = req_tgl ^ seen_q;
    seen_d = fire ? req_tgl : seen_q;
    if (!fire)      kind = ACC_IDLE;
    else if (wr_en) kind = ACC_STORE;
    else            kind = ACC_LOAD;
  end

  always_ff @(negedge clk or negedge rst_q) begin
    if (!rst_q)    seen_q <= 1'b0;
    else if (fire) seen_q <= seen_d;
  end
endmodule

// File: rtl/trp_ram_core.sv
module trp_ram_core
  import trp_pkg::*;
#(
  parameter int unsigned DW = TRP_DW,
  parameter int unsigned AW = TRP_AW
) (
  input  logic          clk,
  input  logic          rst_q,
  input  acc_kind_e     kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;
  logic          wr_go;
  logic          rd_go;

  always_comb begin
    wr_go   = (kind == ACC_STORE);
    rd_go   = (kind == ACC_LOAD);
    rdata_d = rd_go ? mem_q[addr] : rdata_q;
  end

  always_ff @(negedge clk) begin
    if (wr_go) mem_q[addr] <= wdata;
  end

  always_ff @(negedge clk or negedge rst_q) begin
    if (!rst_q)     rdata_q <= '0;
    else if (rd_go) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/toggle_ram_port.sv
module toggle_ram_port
  import trp_pkg::*;
#(
  parameter int unsigned DW = TRP_DW,
  parameter int unsigned AW = TRP_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic      rst_q;
  logic      fire;
  logic      seen_q;
  acc_kind_e kind;

  trp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_q  (rst_q)
  );

  trp_req_track u_track (
    .clk     (clk),
    .rst_q   (rst_q),
    .req_tgl (req_tgl),
    .wr_en   (wr_en),
    .fire    (fire),
    .seen_q  (seen_q),
    .kind    (kind)
  );

  trp_ram_core #(.DW(DW), .AW(AW)) u_core (
    .clk   (clk),
    .rst_q (rst_q),
    .kind  (kind),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );
endmodule

// File: rtl/trp_checker.sv
module trp_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_q,
  input logic          req_tgl,
  input logic          wr_en,
  input logic          fire,
  input logic          seen_q,
  input logic [DW-1:0] rdata
);
  // R4: no pending request means rdata does not move at the next falling edge
  assert_idle_hold_R4: assert property (@(negedge clk) disable iff (!rst_q)
    !fire |=> $stable(rdata));

  // R7: a store never disturbs the load data
  assert_store_keeps_rdata_R7: assert property (@(negedge clk) disable iff (!rst_q)
    (fire && wr_en) |=> $stable(rdata));

  // R6: after an access the tracked copy equals the request that was served
  assert_seen_follows_R6: assert property (@(negedge clk) disable iff (!rst_q)
    fire |=> (seen_q == $past(req_tgl)));

  // R8: one access clears the pending state unless the line moves again
  assert_selfclear_R8: assert property (@(negedge clk) disable iff (!rst_q)
    fire ##1 $stable(req_tgl) |-> !fire);

  // R1: the first falling edge out of reset finds no pending request
  assert_quiet_after_reset_R1: assert property (@(negedge clk)
    $rose(rst_q) |-> (!fire && seen_q == 1'b0));
endmodule

bind toggle_ram_port trp_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .req_tgl (req_tgl),
  .wr_en   (wr_en),
  .fire    (fire),
  .seen_q  (seen_q),
  .rdata   (rdata)
);

// File: tb/toggle_ram_port_test.sv
module toggle_ram_port_test;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_tgl;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [DW-1:0] m_mem [WORDS];
  logic          m_seen;
  logic [DW-1:0] m_rdata;

  always #2.5 clk = ~clk;

  toggle_ram_port #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one datapath cycle: drive after the rising edge, compare after the falling edge
  task automatic step(input bit flip, input bit we, input int a, input logic [DW-1:0] d,
                      input string tag);
    @(posedge clk);
    #1;
    if (flip) req_tgl = ~req_tgl;
    wr_en = we;
    addr  = AW'(a);
    wdata = d;
    @(negedge clk);
    #1;
    if (req_tgl != m_seen) begin
      m_seen = req_tgl;
      if (we) m_mem[a] = d;
      else    m_rdata  = m_mem[a];
    end
    check(tag, rdata, m_rdata);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_tgl = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_seen = 1'b0; m_rdata = '0;
    for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", rdata, '0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, i, 32'h0, "R1 idle");

    // fill every address with back-to-back stores (both toggle directions)
    for (int i = 0; i < WORDS; i++)
      step(1'b1, 1'b1, i, 32'hA5000000 ^ (i * 32'h01010101), "R3 R6 R9 store");
    // back-to-back loads
    for (int i = 0; i < WORDS; i++) step(1'b1, 1'b0, i, 32'hDEAD0000, "R2 R6 R8 load");
    check("R9 top address", rdata, 32'hA5000000 ^ ((WORDS - 1) * 32'h01010101));

    // level held while store-like inputs move: nothing may happen
    step(1'b1, 1'b0, 5, '0, "R2 load");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i, 32'hFFFF0000 + i, "R4 held level");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, i, '0, "R4 readback");

    // loads leave contents intact: read twice
    step(1'b1, 1'b0, 9, '0, "R5 read1");
    step(1'b1, 1'b0, 9, '0, "R5 read2");

    // stores keep rdata
    step(1'b1, 1'b0, 12, '0, "R7 load");
    step(1'b1, 1'b1, 12, 32'h12345678, "R7 store keeps rdata");
    step(1'b1, 1'b1, 0, 32'h87654321, "R7 store keeps rdata");
    step(1'b0, 1'b0, 0, '0, "R7 idle");
    step(1'b1, 1'b0, 12, '0, "R3 stored word");
    check("R3 explicit", rdata, 32'h12345678);
    step(1'b1, 1'b0, 0, '0, "R3 stored word");
    check("R3 explicit", rdata, 32'h87654321);

    // alternating gaps, both directions
    for (int i = 0; i < 8; i++) begin
      step(1'b1, i[0], 40 + i, 32'h0C0C0000 + i, "R8 gap access");
      step(1'b0, 1'b0, 40, '0, "R8 gap idle");
    end
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 40 + i, '0, "R8 gap readback");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule